// File: doc/BRIEF.md
# Bypassable Sixteen-Bit Integer Clock Divider

This block derives a slower clock for an audio serial link from a parent clock. A 32-bit control register sets its behaviour. The upper half holds a 16-bit integer divisor and the two lowest bits form an enable pair. When the divisor is 2 or larger and both enable bits are set, the output runs at the parent rate divided by the divisor. A divisor of 0 or 1 makes the output a copy of the parent clock, whatever the enable bits hold.

Software can load the register with a raw bus write and read it back to see the effective setting. It can also use three command strobes. One enables the divider using the divisor already held. One stops the divider and clears the register. One programs a rate from a parent frequency and a target frequency. A new divisor that arrives while the divider runs waits for the end of the current output period, so no period is ever cut short.

Top module: `clkdiv_top`

## Requirements
- R1: After reset the register reads 0, so the output is in bypass and follows the parent clock.
- R2: When the divisor field (bits 31:16) is 0 or 1, `clk_out` equals `clk`, whatever bits 1:0 hold.
- R3: When bits 1:0 are 2'b11 and the divisor N is 2 or more, `clk_out` repeats with a period of N parent cycles. It is high for N/2 cycles, rounded down, and low for the remaining cycles.
- R4: When the divisor is 2 or more and bits 1:0 are not 2'b11, `clk_out` stays low.
- R5: A pulse on `wr_en` stores `wr_data` in the register, and `rd_data` always shows the register.
- R6: When the divisor is 2 or more, `op_enable` writes {divisor, 16'h0003} to the register. When the divisor is below 2, it leaves the register unchanged.
- R7: `op_disable` writes 0 to the whole register.
- R8: `op_rate` computes q from the low 16 bits of `rate_parent / rate_target`. If q is 2 or more, it writes {q, 16'h0000}. If q is below 2, or the target is 0, it writes 0.
- R9: A divisor change made while the divider runs takes effect only after the current output period has completed.
- R10: When several requests arrive in one cycle, the priority is `op_disable`, then `op_rate`, then `op_enable`, then `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Raw register write strobe |
| wr_data | input | 32 | Raw register write value |
| rd_data | output | 32 | Current register contents |
| op_enable | input | 1 | Enable command strobe |
| op_disable | input | 1 | Disable command strobe |
| op_rate | input | 1 | Rate programming command strobe |
| rate_parent | input | RATE_W | Parent frequency for rate programming |
| rate_target | input | RATE_W | Target frequency for rate programming |
| clk_out | output | 1 | Divided or bypassed clock |

## Verification
A table of even and odd divisors, 2, 3, 4, 7, 10 and 17, is run through the divider. For each one the bench measures the high and low run lengths of the output. This separates correct floor/remainder duty splitting from off-by-one counting, and it shows whether both halves scale with N.

Directed cases cover several conditions:
- bypass with the enable bits both set and clear;
- a divider that is disabled but holds a valid divisor;
- enabling with a divisor of 1;
- rate quotients that truncate, fall below 2, or have a zero target;
- colliding command strobes.

A divisor change in the middle of the high phase checks that the old period completes before the new one starts.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W = 16;
  localparam int REG_W = 2 * DIV_W;
  localparam logic [1:0] EN_ON = 2'b11;

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [REG_W-1:0] reg_t;

  // divisor values 0 and 1 select the parent clock directly
  function automatic logic is_bypass(div_t d);
    return d < div_t'(2);
  endfunction

  // number of parent cycles the output spends high in one period
  function automatic div_t high_len(div_t d);
    return d >> 1;
  endfunction

  function automatic div_t div_field(reg_t r);
    return r[REG_W-1:DIV_W];
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_t              wr_data,
  input  logic              op_enable,
  input  logic              op_disable,
  input  logic              op_rate,
  input  logic [RATE_W-1:0] rate_parent,
  input  logic [RATE_W-1:0] rate_target,
  output reg_t              ctrl_q
);
  // truncated quotient; a zero target yields zero
  function automatic div_t rate_quot(logic [RATE_W-1:0] p, logic [RATE_W-1:0] t);
    logic [RATE_W-1:0] q;
    if (t == '0) return '0;
    q = p / t;
    return q[DIV_W-1:0];
  endfunction

  div_t quot;
  div_t cur_div;
  reg_t ctrl_d;

  assign quot    = rate_quot(rate_parent, rate_target);
  assign cur_div = div_field(ctrl_q);

  always_comb begin
    ctrl_d = ctrl_q;
    if (op_disable) begin
      ctrl_d = '0;
    end else if (op_rate) begin
      ctrl_d = is_bypass(quot) ? '0 : {quot, {DIV_W{1'b0}}};
    end else if (op_enable) begin
      if (!is_bypass(cur_div)) ctrl_d = {cur_div, {(DIV_W-2){1'b0}}, EN_ON};
    end else if (wr_en) begin
      ctrl_d = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_disable |=> (ctrl_q == '0));

  assert_enable_keeps_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_enable && !op_disable && !op_rate && !is_bypass(cur_div))
    |=> (ctrl_q[1:0] == EN_ON) && (div_field(ctrl_q) == $past(cur_div)));

  assert_rate_low_half_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rate && !op_disable) |=> (ctrl_q[DIV_W-1:0] == '0));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  div_t       div_i,
  input  logic [1:0] en_i,
  output logic       div_clk_o,
  output logic       bypass_o
);
  logic run;
  logic live_q;
  div_t cnt_q, cnt_d;
  div_t act_q, act_d;
  logic out_d;
  logic wrap;

  assign bypass_o = is_bypass(div_i);
  assign run      = (en_i == EN_ON) && !bypass_o;
  assign wrap     = live_q && (cnt_q == act_q - div_t'(1));

  always_comb begin
    if (!run || !live_q || wrap) begin
      cnt_d = '0;
      act_d = div_i;
    end else begin
      cnt_d = cnt_q + div_t'(1);
      act_d = act_q;
    end
    out_d = run && (cnt_d < high_len(act_d));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_q     <= '0;
      live_q    <= 1'b0;
      div_clk_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      act_q     <= act_d;
      live_q    <= run;
      div_clk_o <= out_d;
    end
  end

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !div_clk_o);

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (cnt_q < act_q) && (act_q >= div_t'(2)));

  assert_div_held_midperiod_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live_q && !wrap) |=> $stable(act_q));
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              op_enable,
  input  logic              op_disable,
  input  logic              op_rate,
  input  logic [RATE_W-1:0] rate_parent,
  input  logic [RATE_W-1:0] rate_target,
  output logic              clk_out
);
  reg_t ctrl_q;
  logic div_clk;
  logic bypass;

  clkdiv_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .op_enable   (op_enable),
    .op_disable  (op_disable),
    .op_rate     (op_rate),
    .rate_parent (rate_parent),
    .rate_target (rate_target),
    .ctrl_q      (ctrl_q)
  );

  clkdiv_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_i     (div_field(ctrl_q)),
    .en_i      (ctrl_q[1:0]),
    .div_clk_o (div_clk),
    .bypass_o  (bypass)
  );

  assign rd_data = ctrl_q;
  assign clk_out = bypass ? clk : div_clk;

  assert_reset_bypass_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0));
endmodule

// File: tb/tb_clkdiv_top.sv
module tb_clkdiv_top;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // divisor, expected high run, expected low run
  localparam int VEC [NV][3] = '{'{2,1,1}, '{3,1,2}, '{4,2,2}, '{7,3,4}, '{10,5,5}, '{17,8,9}};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, op_enable = 0, op_disable = 0, op_rate = 0;
  logic [31:0] wr_data = '0, rate_parent = '0, rate_target = '0;
  logic [31:0] rd_data;
  logic clk_out;
  logic smp;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  clkdiv_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .op_enable(op_enable), .op_disable(op_disable), .op_rate(op_rate),
    .rate_parent(rate_parent), .rate_target(rate_target), .clk_out(clk_out));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1; smp = clk_out;
  endtask

  task automatic bus_wr(input logic [31:0] v);
    wr_en = 1; wr_data = v; step(); wr_en = 0;
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (smp == v && n < 5000) begin n++; step(); end
  endtask

  task automatic find_rise();
    logic prev;
    prev = 1'b1;
    for (int g = 0; g < 5000; g++) begin
      step();
      if (!prev && smp) break;
      prev = smp;
    end
  endtask

  task automatic check_bypass(input string req);
    @(posedge clk); #2; chk(clk_out == 1'b1, req, clk_out, 1);
    @(negedge clk); #2; chk(clk_out == 1'b0, req, clk_out, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, lo, h2, l2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk(rd_data == 32'h0, "R1 reset value", rd_data, 0);
    check_bypass("R1 reset bypass");

    // R3 vector walk
    for (int i = 0; i < NV; i++) begin
      bus_wr({VEC[i][0][15:0], 16'h0003});
      find_rise();
      run_len(1'b1, hi);
      run_len(1'b0, lo);
      chk(hi == VEC[i][1], $sformatf("R3 high N=%0d", VEC[i][0]), hi, VEC[i][1]);
      chk(lo == VEC[i][2], $sformatf("R3 low N=%0d", VEC[i][0]), lo, VEC[i][2]);
    end

    // R5 raw write readback
    bus_wr(32'h0005_0001);
    chk(rd_data == 32'h0005_0001, "R5 readback", rd_data, 32'h0005_0001);
    // R4 held low when enable pair incomplete
    hi = 0;
    for (int k = 0; k < 20; k++) begin step(); if (smp) hi++; end
    chk(hi == 0, "R4 held low", hi, 0);

    // R2 bypass with enable bits set and clear
    bus_wr(32'h0001_0003);
    check_bypass("R2 bypass enabled");
    bus_wr(32'h0000_0000);
    check_bypass("R2 bypass div0");

    // R6 enable with divisor 1 changes nothing
    bus_wr(32'h0001_0100);
    op_enable = 1; step(); op_enable = 0;
    chk(rd_data == 32'h0001_0100, "R6 enable no-op", rd_data, 32'h0001_0100);
    // R6 enable with divisor 6
    bus_wr(32'h0006_0100);
    op_enable = 1; step(); op_enable = 0;
    chk(rd_data == 32'h0006_0003, "R6 enable", rd_data, 32'h0006_0003);
    find_rise(); run_len(1'b1, hi); run_len(1'b0, lo);
    chk(hi == 3 && lo == 3, "R6 enabled period", {hi, lo}, {32'd3, 32'd3});

    // R7 disable
    op_disable = 1; step(); op_disable = 0;
    chk(rd_data == 32'h0, "R7 disable", rd_data, 0);

    // R8 rate programming
    rate_parent = 1000; rate_target = 100;
    op_rate = 1; step(); op_rate = 0;
    chk(rd_data == 32'h000A_0000, "R8 rate 10", rd_data, 32'h000A_0000);
    rate_parent = 1000; rate_target = 600;
    op_rate = 1; step(); op_rate = 0;
    chk(rd_data == 32'h0, "R8 quotient 1", rd_data, 0);
    rate_parent = 32'h0001_2345; rate_target = 1;
    op_rate = 1; step(); op_rate = 0;
    chk(rd_data == 32'h2345_0000, "R8 truncation", rd_data, 32'h2345_0000);
    rate_target = 0;
    op_rate = 1; step(); op_rate = 0;
    chk(rd_data == 32'h0, "R8 zero target", rd_data, 0);

    // R10 priority
    bus_wr(32'h0009_0000);
    op_disable = 1; op_rate = 1; rate_parent = 50; rate_target = 5; step();
    op_disable = 0; op_rate = 0;
    chk(rd_data == 32'h0, "R10 disable wins", rd_data, 0);
    op_rate = 1; op_enable = 1; wr_en = 1; wr_data = 32'hFFFF_FFFF; step();
    op_rate = 0; op_enable = 0; wr_en = 0;
    chk(rd_data == 32'h000A_0000, "R10 rate wins", rd_data, 32'h000A_0000);
    bus_wr(32'h0004_0000);
    op_enable = 1; wr_en = 1; wr_data = 32'h0002_0000; step();
    op_enable = 0; wr_en = 0;
    chk(rd_data == 32'h0004_0003, "R10 enable wins", rd_data, 32'h0004_0003);

    // R9 divisor change mid-period
    bus_wr(32'h0008_0003);
    find_rise();
    bus_wr(32'h0004_0003);
    run_len(1'b1, hi); run_len(1'b0, lo);
    run_len(1'b1, h2); run_len(1'b0, l2);
    chk(hi == 3 && lo == 4, "R9 old period completes", {hi, lo}, {32'd3, 32'd4});
    chk(h2 == 2 && l2 == 2, "R9 new period", {h2, l2}, {32'd2, 32'd2});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule